// File: doc/BRIEF.md
# Byte-Program SPI Master

This block is a half-duplex SPI master driven by a small program. Software loads a 64-bit transmit word, then writes a 64-bit program word that holds up to eight one-byte opcodes. The sequencer walks the opcodes from the top byte down. They select a slave, shift bytes out of the transmit word, shift bytes into the receive word, copy the receive word into the transmit word, or jump to another slot. Software then polls a status word. That word reports the fill state of both data words, sticky overrun, underrun and opcode-error flags, and a one-hot sequencer state.

Software reaches the block through a simple 64-bit register port. A write strobe or a read strobe comes with a 4-bit word offset. Read data is combinational on the offset, and the read strobe marks the cycle in which a read takes effect. The serial side runs in SPI mode 0, most significant bit first. SCK is derived from the system clock by a 12-bit divider. A two-write sequence on the clock configuration word returns the controller to its idle state.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, status reads 64'h0001_0000_0000_0000 (only bit 48 set), every chip select is high and SCK is low. Offsets 0x0, 0x1, 0x2, 0x4 and 0x9 read as zero. Offset 0x3 is clock config, 0x5 TX data, 0x6 RX data, 0x7 program and 0x8 status.
- R2: A program write at offset 0x7 while the sequencer is idle starts execution at slot 0, the byte in bits 63:56. Later slots come from lower bytes. Opcode 0x00, or running past slot 7, returns the sequencer to idle. A program write while it is not idle is ignored. Status bits 55:48 read 0x01 when idle, 0x02 when decoding, 0x04 when waiting for TX data and 0x08 when shifting.
- R3: Opcode 0x1n drives chip select n-1 low, with every other select high. For n = 0 or n above the number of selects, all selects are high. Selects do not change during a shift.
- R4: Opcode 0x3n shifts out n bytes, starting with bit 63 of the TX word. n above 8 counts as 8, and n = 0 does nothing. MOSI only changes while SCK is low, and SCK is low whenever no shift is running. TX-full (status bit 59) clears when the shift starts.
- R5: Opcode 0x4n shifts in n bytes. The bytes land right-aligned in the RX word, with the first byte received in the highest byte of that group. RX-full (status bit 63) is set when the shift ends and clears when offset 0x6 is read.
- R6: The SCK period is 2 x (D + 1) system clocks, where D is clock config bits 63:52.
- R7: A TX write while TX-full is set sets TX overrun (bit 58) and the new data is dropped. A shift-out found with TX-full clear sets TX underrun (bit 57), and the sequencer waits in state 0x04 until TX data is written.
- R8: Finishing a shift-in while RX-full is set sets RX overrun (bit 62), and the new data replaces the old. Reading offset 0x6 while RX-full is clear sets RX underrun (bit 61).
- R9: Opcode 0xC0 copies the RX word into the TX word and sets TX-full. Opcode 0xEn continues at slot n mod 8.
- R10: Any other opcode sets status bit 31 and returns the sequencer to idle without executing it.
- R11: Any write to status clears bits 62, 61, 58, 57 and 31.
- R12: A clock config write with bits 39:36 = 0101, followed directly by a clock config write with bits 39:36 = 1010, clears both data words, all flags, the program and the selects, and makes the sequencer idle. A clock config write with bits 39:36 nonzero leaves the divider unchanged. The second step alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low slave selects |

## Verification
The bench builds the block with its defaults: four selects and a 12-bit divider field. With four selects, every valid select code (0x11 to 0x14) can be checked, and so can an out-of-range code (0x15). Random transfers use dividers 0 to 2, which keeps each run short while still covering both the one-cycle half period and longer ones. One directed case uses divider 3 to hold the sequencer busy long enough to test a program write arriving mid-run.

// File: rtl/spi_seq_pkg.sv
// Shared widths, register offsets and sequencer state type for the
// byte-program SPI master. Assumes a 64-bit register word.
package spi_seq_pkg;
    localparam int WORD_W = 64;
    localparam int OP_W   = 8;
    localparam int SLOTS  = WORD_W / OP_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int DIV_W  = 12;
    localparam int ADDR_W = 4;
    localparam int NIB_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CLKCFG = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_TXD    = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_RXD    = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_PROG   = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'h8;

    localparam logic [OP_W-1:0] CODE_IDLE  = 8'h01;
    localparam logic [OP_W-1:0] CODE_EXEC  = 8'h02;
    localparam logic [OP_W-1:0] CODE_WAIT  = 8'h04;
    localparam logic [OP_W-1:0] CODE_SHIFT = 8'h08;

    typedef enum logic [1:0] {SQ_IDLE, SQ_EXEC, SQ_WAIT_TX, SQ_SHIFT} seq_state_t;
endpackage

// File: rtl/spi_shift_engine.sv
// Shift engine: runs one SPI mode-0 burst of nbytes*8 bits, MSB first.
// SCK half period is div+1 clocks. A burst is loaded on start and must
// not be restarted while busy. abort returns it to idle at once.
module spi_shift_engine
    import spi_seq_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic              dir_in,
    input  logic [NIB_W-1:0]  nbytes,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DW-1:0]     div,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BITS_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh_out;
    logic [WORD_W-1:0] sh_in;
    logic [BITS_W-1:0] bits_left;
    logic [DW-1:0]     half_cnt;

    // Burst control: half-period counting, SCK toggling, sampling and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            sh_out    <= '0;
            sh_in     <= '0;
            bits_left <= '0;
            half_cnt  <= '0;
            sck       <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                sck       <= 1'b0;
                half_cnt  <= '0;
                bits_left <= BITS_W'({nbytes, 3'b000});
                sh_out    <= dir_in ? '0 : tx_word;
                sh_in     <= '0;
            end else if (busy) begin
                if (half_cnt >= div) begin
                    half_cnt <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        sh_in <= {sh_in[WORD_W-2:0], miso};
                    end else begin
                        sck       <= 1'b0;
                        sh_out    <= {sh_out[WORD_W-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == BITS_W'(1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end
        end
    end

    // Output data: top bit of the out-shifter, forced low when idle.
    always_comb begin
        mosi    = busy & sh_out[WORD_W-1];
        rx_word = sh_in;
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck) else $error("SCK high while idle"); // R4

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck) |-> $stable(mosi)) else $error("MOSI moved with SCK high"); // R4
endmodule

// File: rtl/spi_seq_ctrl.sv
// Sequencer: holds the 8-slot program and executes one opcode per cycle,
// handing shift bursts to the engine and waiting for its done pulse.
// Assumes the engine raises done exactly once per accepted start.
module spi_seq_ctrl
    import spi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              prog_wr,
    input  logic [WORD_W-1:0] prog_wdata,
    input  logic              tx_full,
    input  logic              eng_done,
    output logic              eng_start,
    output logic              start_dir,
    output logic [NIB_W-1:0]  start_nbytes,
    output logic              tx_take,
    output logic              rx_store,
    output logic              copy_tx,
    output logic              tx_und_evt,
    output logic              op_err_evt,
    output logic [NIB_W-1:0]  sel,
    output logic [WORD_W-1:0] prog_q,
    output logic [OP_W-1:0]   state_code
);
    seq_state_t        state;
    logic [SLOT_W:0]   pc;
    logic              cur_dir;
    logic [NIB_W-1:0]  cur_nb;
    logic [OP_W-1:0]   op;
    logic [NIB_W-1:0]  op_hi, op_lo, n_clamp;
    logic              live, is_out, is_in, is_bad;

    // Decode of the opcode in the current slot.
    always_comb begin
        op      = OP_W'(prog_q >> {~pc[SLOT_W-1:0], 3'b000});
        op_hi   = op[7:4];
        op_lo   = op[3:0];
        n_clamp = (op_lo > 4'd8) ? 4'd8 : op_lo;
        live    = (state == SQ_EXEC) && !pc[SLOT_W];
        is_out  = live && (op_hi == 4'h3) && (n_clamp != '0);
        is_in   = live && (op_hi == 4'h4) && (n_clamp != '0);
        unique case (op_hi)
            4'h0:    is_bad = (op_lo != '0);
            4'h1, 4'h3, 4'h4, 4'hE: is_bad = 1'b0;
            4'hC:    is_bad = (op_lo != '0);
            default: is_bad = 1'b1;
        endcase
    end

    // Handshake strobes towards the engine and the register file.
    always_comb begin
        eng_start    = (is_out && tx_full) || is_in || ((state == SQ_WAIT_TX) && tx_full);
        start_dir    = is_in;
        start_nbytes = (state == SQ_WAIT_TX) ? cur_nb : n_clamp;
        tx_take      = eng_start && !start_dir;
        rx_store     = (state == SQ_SHIFT) && eng_done && cur_dir;
        copy_tx      = live && (op == 8'hC0);
        tx_und_evt   = is_out && !tx_full;
        op_err_evt   = live && is_bad;
        unique case (state)
            SQ_IDLE:    state_code = CODE_IDLE;
            SQ_EXEC:    state_code = CODE_EXEC;
            SQ_WAIT_TX: state_code = CODE_WAIT;
            default:    state_code = CODE_SHIFT;
        endcase
    end

    // Program storage, slot pointer, selects and state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state   <= SQ_IDLE;
            pc      <= '0;
            sel     <= '0;
            prog_q  <= '0;
            cur_dir <= 1'b0;
            cur_nb  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (prog_wr) begin
                    prog_q <= prog_wdata;
                    pc     <= '0;
                    state  <= SQ_EXEC;
                end
                SQ_EXEC: begin
                    if (pc[SLOT_W] || is_bad || op == 8'h00) begin
                        state <= SQ_IDLE;
                    end else begin
                        unique case (op_hi)
                            4'h1: begin sel <= op_lo; pc <= pc + 1'b1; end
                            4'hE: pc <= {1'b0, op_lo[SLOT_W-1:0]};
                            4'h3, 4'h4: begin
                                if (n_clamp == '0) begin
                                    pc <= pc + 1'b1;
                                end else begin
                                    cur_nb  <= n_clamp;
                                    cur_dir <= (op_hi == 4'h4);
                                    state   <= (op_hi == 4'h4 || tx_full) ? SQ_SHIFT : SQ_WAIT_TX;
                                end
                            end
                            default: pc <= pc + 1'b1;
                        endcase
                    end
                end
                SQ_WAIT_TX: if (tx_full) state <= SQ_SHIFT;
                default: if (eng_done) begin
                    pc    <= pc + 1'b1;
                    state <= SQ_EXEC;
                end
            endcase
        end
    end

    AST_DONE_WHILE_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> (state == SQ_SHIFT)) else $error("engine done outside shift state"); // R2
endmodule

// File: rtl/spi_seq_master.sv
// Top of the byte-program SPI master: register file, status flags,
// two-step soft reset, select decode, sequencer and shift engine.
// Assumes reg_we and reg_re are single-cycle strobes, never both at once.
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam logic [3:0] STEP_A = 4'b0101;
    localparam logic [3:0] STEP_B = 4'b1010;

    logic [WORD_W-1:0] tx_q, rx_q, prog_q, eng_rx;
    logic              tx_full, rx_full, tx_ovr, tx_und, rx_ovr, rx_und, op_err;
    logic [DIV_W-1:0]  div_q;
    logic              step_a_seen, soft_rst;
    logic              tx_wr, rx_rd, clk_wr, stat_wr, prog_wr;
    logic              eng_start, start_dir, eng_busy, eng_done;
    logic [NIB_W-1:0]  start_nb, sel;
    logic              tx_take, rx_store, copy_tx, tx_und_evt, op_err_evt;
    logic [OP_W-1:0]   state_code;

    // Strobe decode of the register port.
    always_comb begin
        tx_wr    = reg_we && (reg_addr == OFS_TXD);
        rx_rd    = reg_re && (reg_addr == OFS_RXD);
        clk_wr   = reg_we && (reg_addr == OFS_CLKCFG);
        stat_wr  = reg_we && (reg_addr == OFS_STAT);
        prog_wr  = reg_we && (reg_addr == OFS_PROG);
        soft_rst = clk_wr && step_a_seen && (reg_wdata[39:36] == STEP_B);
    end

    // Clock configuration: divider storage and reset-step tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q       <= '0;
            step_a_seen <= 1'b0;
        end else if (clk_wr) begin
            step_a_seen <= (reg_wdata[39:36] == STEP_A);
            if (reg_wdata[39:36] == 4'b0000)
                div_q <= reg_wdata[WORD_W-1 -: DIV_W];
        end
    end

    // Data words, fill state and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tx_q <= '0; rx_q <= '0;
            tx_full <= 1'b0; rx_full <= 1'b0;
            tx_ovr <= 1'b0; tx_und <= 1'b0;
            rx_ovr <= 1'b0; rx_und <= 1'b0;
            op_err <= 1'b0;
        end else begin
            if (stat_wr) begin
                tx_ovr <= 1'b0; tx_und <= 1'b0;
                rx_ovr <= 1'b0; rx_und <= 1'b0;
                op_err <= 1'b0;
            end
            if (tx_take) tx_full <= 1'b0;
            if (copy_tx) begin
                tx_q    <= rx_q;
                tx_full <= 1'b1;
            end
            if (tx_wr) begin
                if (tx_full) tx_ovr <= 1'b1;
                else begin
                    tx_q    <= reg_wdata;
                    tx_full <= 1'b1;
                end
            end
            if (tx_und_evt) tx_und <= 1'b1;
            if (op_err_evt) op_err <= 1'b1;
            if (rx_rd) begin
                if (rx_full) rx_full <= 1'b0;
                else         rx_und  <= 1'b1;
            end
            if (rx_store) begin
                rx_q    <= eng_rx;
                rx_full <= 1'b1;
                if (rx_full && !rx_rd) rx_ovr <= 1'b1;
            end
        end
    end

    // Read data multiplexer; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CLKCFG: reg_rdata[WORD_W-1 -: DIV_W] = div_q;
            OFS_TXD:    reg_rdata = tx_q;
            OFS_RXD:    reg_rdata = rx_q;
            OFS_PROG:   reg_rdata = prog_q;
            OFS_STAT: begin
                reg_rdata[63]    = rx_full;
                reg_rdata[62]    = rx_ovr;
                reg_rdata[61]    = rx_und;
                reg_rdata[59]    = tx_full;
                reg_rdata[58]    = tx_ovr;
                reg_rdata[57]    = tx_und;
                reg_rdata[55:48] = state_code;
                reg_rdata[31]    = op_err;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Select decode: one active-low line per slave number 1..NUM_CS.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign spi_cs_n[gi] = (sel != NIB_W'(gi + 1));
    end

    spi_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .prog_wr      (prog_wr),
        .prog_wdata   (reg_wdata),
        .tx_full      (tx_full),
        .eng_done     (eng_done),
        .eng_start    (eng_start),
        .start_dir    (start_dir),
        .start_nbytes (start_nb),
        .tx_take      (tx_take),
        .rx_store     (rx_store),
        .copy_tx      (copy_tx),
        .tx_und_evt   (tx_und_evt),
        .op_err_evt   (op_err_evt),
        .sel          (sel),
        .prog_q       (prog_q),
        .state_code   (state_code)
    );

    spi_shift_engine #(.DW(DIV_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (soft_rst),
        .start   (eng_start),
        .dir_in  (start_dir),
        .nbytes  (start_nb),
        .tx_word (tx_q),
        .div     (div_q),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_word (eng_rx)
    );

    AST_CS_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !soft_rst) |=> $stable(spi_cs_n)) else $error("select moved mid-shift"); // R3

    AST_RX_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && !soft_rst) |=> rx_full) else $error("RX not full after shift-in"); // R5

    AST_TAKE_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_full) else $error("TX still full after take"); // R4
endmodule

// File: tb/spi_seq_master_test.sv
`timescale 1ns/1ps
module spi_seq_master_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;
    logic         spi_sck, spi_mosi, spi_miso;
    logic [3:0]   spi_cs_n;

    int           checks = 0, errors = 0, cyc = 0;
    bit           finished = 1'b0;
    logic [127:0] cap, slave_pat;
    int           cap_n, s_idx;
    logic [3:0]   cs_seen;
    longint       last_rise, period;
    bit           have_rise;

    always #5 clk = ~clk;

    spi_seq_master uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Slave model: presents the next pattern bit after each falling SCK.
    assign spi_miso = (s_idx < 128) ? slave_pat[127 - s_idx] : 1'b0;
    always @(negedge spi_sck) s_idx = s_idx + 1;
    always @(posedge spi_sck) begin
        cap = {cap[126:0], spi_mosi};
        cap_n = cap_n + 1;
        cs_seen = spi_cs_n;
        if (have_rise) period = $time - last_rise;
        last_rise = $time;
        have_rise = 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected <150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [63:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [63:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [63:0] s;
        for (int i = 0; i < 6000; i++) begin
            rd(4'h8, s);
            if (s[55:48] == 8'h01) return;
        end
        chk("R2 idle timeout", {64'b0, s}, 128'h1);
    endtask

    task automatic arm(logic [127:0] pat);
        cap = '0; cap_n = 0; s_idx = 0; slave_pat = pat; have_rise = 1'b0; cs_seen = 4'hF;
    endtask

    function automatic logic [63:0] prog(logic [7:0] a, b, c, d, e, f, g, h);
        return {a, b, c, d, e, f, g, h};
    endfunction

    function automatic logic [127:0] exp_mosi(logic [63:0] tx, int nout, int nin);
        logic [127:0] w = {64'b0, tx} >> (64 - 8 * nout);
        return w << (8 * nin);
    endfunction

    function automatic logic [63:0] exp_rx(logic [127:0] pat, int nout, int nin);
        logic [127:0] w = (pat << (8 * nout)) >> (128 - 8 * nin);
        return w[63:0];
    endfunction

    task automatic xfer(int cs, int nout, int nin, int dv, logic [63:0] txw, logic [127:0] pat);
        logic [63:0] s, r;
        wr(4'h3, {12'(dv), 52'b0});
        wr(4'h5, txw);
        arm(pat);
        wr(4'h7, prog(8'(8'h10 + cs), 8'(8'h30 + nout),
                      (nin > 0) ? 8'(8'h40 + nin) : 8'h10, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00));
        wait_idle();
        chk("R4 mosi bits", cap, exp_mosi(txw, nout, nin));
        chk("R4 bit count", 128'(cap_n), 128'(8 * (nout + nin)));
        chk("R3 select during shift", {124'b0, cs_seen}, {124'b0, ~(4'b1 << (cs - 1))});
        chk("R6 sck period", 128'(period), 128'(20 * (dv + 1)));
        rd(4'h8, s);
        chk("R4 tx full clear", {127'b0, s[59]}, 128'b0);
        if (nin > 0) begin
            chk("R5 rx full set", {127'b0, s[63]}, 128'b1);
            rd(4'h6, r);
            chk("R5 rx data", {64'b0, r}, {64'b0, exp_rx(pat, nout, nin)});
            rd(4'h8, s);
            chk("R5 rx full cleared by read", {127'b0, s[63]}, 128'b0);
        end
        chk("R3 selects released", {124'b0, spi_cs_n}, 128'hF);
    endtask

    initial begin
        logic [63:0] s, r;
        logic [127:0] pat;
        void'($urandom(32'h5EED_0042));
        cap = '0; cap_n = 0; s_idx = 0; slave_pat = '0; have_rise = 0; period = 0; cs_seen = 4'hF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and unmapped offsets
        rd(4'h8, s);
        chk("R1 status after reset", {64'b0, s}, {64'b0, 64'h0001_0000_0000_0000});
        chk("R1 selects high", {124'b0, spi_cs_n}, 128'hF);
        chk("R1 sck low", {127'b0, spi_sck}, 128'b0);
        foreach (s[i]) if (i == 0) begin
            logic [63:0] z;
            rd(4'h0, z); chk("R1 offset 0", {64'b0, z}, 128'b0);
            rd(4'h1, z); chk("R1 offset 1", {64'b0, z}, 128'b0);
            rd(4'h2, z); chk("R1 offset 2", {64'b0, z}, 128'b0);
            rd(4'h4, z); chk("R1 offset 4", {64'b0, z}, 128'b0);
            rd(4'h9, z); chk("R1 offset 9", {64'b0, z}, 128'b0);
        end

        // Directed transfers, then random ones (R3 R4 R5 R6)
        xfer(1, 4, 0, 1, 64'hA1B2_C3D4_E5F6_0718, '0);
        xfer(2, 1, 3, 0, 64'h5A00_0000_0000_0000, {64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98});
        for (int it = 0; it < 12; it++) begin
            pat = {$urandom, $urandom, $urandom, $urandom};
            xfer(1 + int'($urandom % 4), 1 + int'($urandom % 8), int'($urandom % 9),
                 int'($urandom % 3), {$urandom, $urandom}, pat);
        end

        // R3: out-of-range select keeps every line high
        wr(4'h3, 64'h0);
        wr(4'h5, 64'hC300_0000_0000_0000);
        arm('0);
        wr(4'h7, prog(8'h15, 8'h31, 8'h10, 0, 0, 0, 0, 0));
        wait_idle();
        chk("R3 select code 5 idle lines", {124'b0, cs_seen}, 128'hF);

        // R4: n=0 does nothing, n>8 clamps to 8
        wr(4'h5, 64'h0123_4567_89AB_CDEF);
        arm('0);
        wr(4'h7, prog(8'h11, 8'h30, 8'h3A, 8'h10, 0, 0, 0, 0));
        wait_idle();
        chk("R4 clamp to 64 bits", 128'(cap_n), 128'd64);
        chk("R4 clamp data", cap, {64'b0, 64'h0123_4567_89AB_CDEF});

        // R7: underrun and wait, then overrun with dropped data
        arm('0);
        wr(4'h7, prog(8'h11, 8'h32, 8'h10, 0, 0, 0, 0, 0));
        repeat (6) @(negedge clk);
        rd(4'h8, s);
        chk("R7 waiting state", {120'b0, s[55:48]}, 128'h04);
        chk("R7 tx underrun", {127'b0, s[57]}, 128'b1);
        wr(4'h5, 64'hBEEF_0000_0000_0000);
        wait_idle();
        chk("R7 data after wait", cap, 128'hBEEF);
        wr(4'h5, 64'h1111_2222_3333_4444);
        wr(4'h5, 64'h9999_8888_7777_6666);
        rd(4'h8, s);
        chk("R7 tx overrun", {127'b0, s[58]}, 128'b1);
        arm('0);
        wr(4'h7, prog(8'h11, 8'h38, 8'h10, 0, 0, 0, 0, 0));
        wait_idle();
        chk("R7 dropped write", cap, {64'b0, 64'h1111_2222_3333_4444});
        wr(4'h8, 64'h0);
        rd(4'h8, s);
        chk("R11 flags cleared", {124'b0, s[62], s[61], s[58], s[57]}, 128'b0);

        // R8: RX underrun on empty read, overrun on second store
        rd(4'h6, r);
        rd(4'h8, s);
        chk("R8 rx underrun", {127'b0, s[61]}, 128'b1);
        arm({64'h0102_0304_0506_0708, 64'h090A_0B0C_0D0E_0F10});
        wr(4'h7, prog(8'h12, 8'h41, 8'h42, 8'h10, 0, 0, 0, 0));
        wait_idle();
        rd(4'h8, s);
        chk("R8 rx overrun", {127'b0, s[62]}, 128'b1);
        rd(4'h6, r);
        chk("R8 newer data kept", {64'b0, r}, 128'h0203);
        wr(4'h8, 64'h0);

        // R9: copy RX to TX, then branch over a bad opcode
        pat = {$urandom, $urandom, $urandom, $urandom};
        arm(pat);
        wr(4'h7, prog(8'h11, 8'h48, 8'hC0, 8'h38, 8'h10, 0, 0, 0));
        wait_idle();
        chk("R9 copy loops RX to MOSI", cap, {64'b0, pat[127:64]});
        rd(4'h6, r);
        wr(4'h5, 64'h7E00_0000_0000_0000);
        arm('0);
        wr(4'h7, prog(8'hE2, 8'hFF, 8'h11, 8'h31, 8'h10, 0, 0, 0));
        wait_idle();
        rd(4'h8, s);
        chk("R9 branch sends byte", cap, 128'h7E);
        chk("R9 skipped opcode no error", {127'b0, s[31]}, 128'b0);

        // R2: program write while busy ignored; stop and slot-end
        wr(4'h3, {12'd3, 52'b0});
        wr(4'h5, 64'hFACE_0000_0000_0000);
        arm('0);
        wr(4'h7, prog(8'h11, 8'h38, 8'h10, 0, 0, 0, 0, 0));
        wr(4'h7, 64'h1234_5678_9ABC_DEF0);
        rd(4'h7, r);
        chk("R2 busy write ignored", {64'b0, r}, {64'b0, prog(8'h11, 8'h38, 8'h10, 0, 0, 0, 0, 0)});
        wait_idle();
        chk("R2 only first program ran", 128'(cap_n), 128'd64);
        wr(4'h3, 64'h0);
        wr(4'h5, 64'hAB00_0000_0000_0000);
        arm('0);
        wr(4'h7, prog(8'h11, 8'h31, 8'h00, 8'h31, 8'h10, 0, 0, 0));
        wait_idle();
        chk("R2 stop ends program", 128'(cap_n), 128'd8);
        wr(4'h7, prog(8'h11, 8'h10, 8'h12, 8'h10, 8'h13, 8'h10, 8'h14, 8'h10));
        wait_idle();
        chk("R2 slot end reaches idle", {124'b0, spi_cs_n}, 128'hF);

        // R10: undefined opcode stops with error flag
        wr(4'h5, 64'h4400_0000_0000_0000);
        arm('0);
        wr(4'h7, prog(8'h11, 8'h77, 8'h31, 8'h10, 0, 0, 0, 0));
        wait_idle();
        rd(4'h8, s);
        chk("R10 error bit", {127'b0, s[31]}, 128'b1);
        chk("R10 no shift after bad opcode", 128'(cap_n), 128'd0);
        chk("R10 tx untouched", {127'b0, s[59]}, 128'b1);
        wr(4'h8, 64'h0);
        rd(4'h8, s);
        chk("R11 error bit cleared", {127'b0, s[31]}, 128'b0);

        // R12: lone second step does nothing; full pair resets
        wr(4'h3, {12'd2, 52'b0});
        wr(4'h3, 64'h0000_00A0_0000_0000);
        rd(4'h8, s);
        chk("R12 lone step keeps tx full", {127'b0, s[59]}, 128'b1);
        rd(4'h6, r);
        wr(4'h3, 64'h0000_0050_0000_0000);
        wr(4'h3, 64'h0000_00A0_0000_0000);
        rd(4'h8, s);
        chk("R12 status after soft reset", {64'b0, s}, {64'b0, 64'h0001_0000_0000_0000});
        chk("R12 selects released", {124'b0, spi_cs_n}, 128'hF);
        rd(4'h5, r);
        chk("R12 tx word cleared", {64'b0, r}, 128'b0);
        rd(4'h3, r);
        chk("R12 divider kept", {64'b0, r}, {64'b0, 12'd2, 52'b0});

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule